// File: doc/BRIEF.md
# Power Mode and Wake-Up Controller

This block is the power-management state machine of a mixed-signal acquisition chip. It holds an eight-bit enable register whose bits drive the enable lines of the analog sub-blocks: master bias, PLL (and with it the clock output), two supply monitors, a signal-detect comparator and the output driver of a general-purpose digital pin. It also records which of four power modes the chip is in: Sleep, Standby, Idle or Run.

Decoded serial commands reach the block as a one-cycle strobe that carries a 5-bit register address and a data byte. A write to the enable register loads all eight bits. The four mode commands carry no data. Each one rewrites the enable bits that belong to its mode. Wake-up comes from two active-low pins, which pass through a synchronizer, and from a one-cycle alarm pulse sent by the real-time clock. The shutdown output stays high while the keep-alive bit or the PLL bit is set. It falls only after a programmable delay that starts when the PLL bit clears.

Top module: `pwr_mode_ctl`

## Requirements
- R1: After reset the enable register reads 0xE1, the mode is Standby (mode encoding Sleep=0, Standby=1, Idle=2, Run=3), shutdown is high and the ADC enable is low. Register bits: 7 keep-alive, 6 PLL, 5 high-supply monitor, 4 low-supply monitor, 3 signal detect, 2 pin output enable, 1 monitor select, 0 bias.
- R2: A command at address 11001 loads the data byte into the enable register as written, one clock after the strobe, and leaves the mode unchanged.
- R3: A command at address 11010 enters Sleep. It clears bits 7, 6, 3 and 0, sets bit 5 to the inverse of bit 1 and sets bit 4 to bit 1, so that only the selected reset monitor stays powered.
- R4: A command at address 11011 enters Standby. It sets bits 7, 6, 5 and 0, clears bit 3 and sets bit 4 to bit 1.
- R5: Commands at 11100 (Idle) and 11101 (Run) set bits 7, 6, 5, 4, 3 and 0. The ADC enable is high only in Run.
- R6: A low level on either wake pin sets bits 7, 6, 5 and 0 after SYNC_STAGES+1 clock edges. If the mode is Sleep it changes to Standby; any other mode is kept.
- R7: An alarm pulse has the same effect as a wake pin, one clock edge after the pulse.
- R8: Shutdown is high whenever bit 7 or bit 6 is set. Once both are clear, it falls exactly SHDN_DLY clock edges after the edge on which bit 6 cleared, or on the next edge if bit 6 was already clear.
- R9: If bit 6 is set again before the delay ends, the delay starts again in full when bit 6 next clears.
- R10: Bits 2 and 1 are kept through every mode command and every wake event.
- R11: If a wake event and a command arrive in the same cycle, the wake's forced bits win over the command's values, and a Sleep result becomes Standby.
- R12: A strobe at any other address, and any address or data presented without the strobe, leave the register and mode unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | One-cycle strobe: a command byte is complete |
| cmd_addr | input | 5 | Register address of the command |
| cmd_data | input | 8 | Data byte (used only by the register write) |
| wake1_n | input | 1 | Active-low wake pin, asynchronous |
| wake2_n | input | 1 | Active-low wake pin, asynchronous |
| alarm_pulse | input | 1 | One-cycle alarm event from the clock block |
| ctl_q | output | 8 | Enable register contents |
| mode_q | output | 2 | Current power mode |
| shdn_o | output | 1 | Shutdown output, high keeps the system alive |
| adc_en | output | 1 | ADC and input buffer enable |
| clkout_en | output | 1 | Clock output enable (follows the PLL bit) |
| dout_oe | output | 1 | Digital pin output enable |
| mon_sel | output | 1 | Reset monitor select: 0 high threshold, 1 low |

## Verification
A command or an alarm pulse changes the register and mode on the first rising edge after it. A wake pin change takes effect after the synchronizer stages plus one edge. The bench checks the pin case one edge early, to confirm that nothing has changed yet, and again on the edge that is due. The shutdown fall is checked at SHDN_DLY-1 edges and again at SHDN_DLY edges after the edge that clears the PLL bit. All inputs are driven and all outputs sampled on the falling edge, so that each sample falls between the update it expects and the next one.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;

   typedef enum logic [1:0] {
      MODE_SLEEP   = 2'd0,
      MODE_STANDBY = 2'd1,
      MODE_IDLE    = 2'd2,
      MODE_RUN     = 2'd3
   } pwr_mode_e;

   localparam int CTL_W  = 8;
   localparam int ADDR_W = 5;

   // enable register bit positions
   localparam int B_KEEP   = 7;
   localparam int B_PLL    = 6;
   localparam int B_MONHI  = 5;
   localparam int B_MONLO  = 4;
   localparam int B_SIGDET = 3;
   localparam int B_DOE    = 2;
   localparam int B_MSEL   = 1;
   localparam int B_BIAS   = 0;

   localparam logic [CTL_W-1:0] CTL_RST = 8'hE1;

   // bits forced high by any wake event
   localparam logic [CTL_W-1:0] WAKE_SET =
      (CTL_W'(1) << B_KEEP) | (CTL_W'(1) << B_PLL) |
      (CTL_W'(1) << B_MONHI) | (CTL_W'(1) << B_BIAS);

   localparam logic [ADDR_W-1:0] A_CTL   = 5'b11001;
   localparam logic [ADDR_W-1:0] A_SLEEP = 5'b11010;
   localparam logic [ADDR_W-1:0] A_STBY  = 5'b11011;
   localparam logic [ADDR_W-1:0] A_IDLE  = 5'b11100;
   localparam logic [ADDR_W-1:0] A_RUN   = 5'b11101;

endpackage

// File: rtl/pwr_wake_sync.sv
module pwr_wake_sync #(
   parameter int NPINS       = 2,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NPINS-1:0] pin_n,
   input  logic             alarm_pulse,
   output logic             wake_evt
);

   logic [NPINS-1:0] pin_s;

   generate
      if (NPINS < 1) begin : g_bad_npins
         $error("pwr_wake_sync: NPINS must be at least 1");
      end
      if (SYNC_STAGES < 0) begin : g_bad_stages
         $error("pwr_wake_sync: SYNC_STAGES must not be negative");
      end

      if (SYNC_STAGES == 0) begin : g_direct
         // pins already synchronous to clk
         assign pin_s = pin_n;
      end else begin : g_chain
         logic [SYNC_STAGES-1:0][NPINS-1:0] chain;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               chain <= '1;
            end else begin
               chain[0] <= pin_n;
               for (int s = 1; s < SYNC_STAGES; s++) begin
                  chain[s] <= chain[s-1];
               end
            end
         end
         assign pin_s = chain[SYNC_STAGES-1];
      end
   endgenerate

   // any pin held low, or the alarm, is a wake event
   assign wake_evt = (~&pin_s) | alarm_pulse;

endmodule

// File: rtl/pwr_ctl_core.sv
module pwr_ctl_core
   import pwr_mode_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   input  logic [ADDR_W-1:0] cmd_addr,
   input  logic [CTL_W-1:0]  cmd_data,
   input  logic              wake_evt,
   output logic [CTL_W-1:0]  ctl_q,
   output pwr_mode_e         mode_q
);

   logic [CTL_W-1:0] ctl_d;
   pwr_mode_e        mode_d;

   always_comb begin
      ctl_d  = ctl_q;
      mode_d = mode_q;
      if (cmd_valid) begin
         unique case (cmd_addr)
            A_CTL: begin
               ctl_d = cmd_data;
            end
            A_SLEEP: begin
               mode_d           = MODE_SLEEP;
               ctl_d[B_KEEP]    = 1'b0;
               ctl_d[B_PLL]     = 1'b0;
               ctl_d[B_SIGDET]  = 1'b0;
               ctl_d[B_BIAS]    = 1'b0;
               ctl_d[B_MONHI]   = ~ctl_q[B_MSEL];
               ctl_d[B_MONLO]   = ctl_q[B_MSEL];
            end
            A_STBY: begin
               mode_d           = MODE_STANDBY;
               ctl_d[B_KEEP]    = 1'b1;
               ctl_d[B_PLL]     = 1'b1;
               ctl_d[B_MONHI]   = 1'b1;
               ctl_d[B_BIAS]    = 1'b1;
               ctl_d[B_SIGDET]  = 1'b0;
               ctl_d[B_MONLO]   = ctl_q[B_MSEL];
            end
            A_IDLE, A_RUN: begin
               mode_d           = (cmd_addr == A_RUN) ? MODE_RUN : MODE_IDLE;
               ctl_d[B_KEEP]    = 1'b1;
               ctl_d[B_PLL]     = 1'b1;
               ctl_d[B_MONHI]   = 1'b1;
               ctl_d[B_MONLO]   = 1'b1;
               ctl_d[B_SIGDET]  = 1'b1;
               ctl_d[B_BIAS]    = 1'b1;
            end
            default: ;
         endcase
      end
      // wake has priority over any same-cycle command
      if (wake_evt) begin
         ctl_d = ctl_d | WAKE_SET;
         if (mode_d == MODE_SLEEP) mode_d = MODE_STANDBY;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_q  <= CTL_RST;
         mode_q <= MODE_STANDBY;
      end else begin
         ctl_q  <= ctl_d;
         mode_q <= mode_d;
      end
   end

endmodule

// File: rtl/pwr_shdn_timer.sv
module pwr_shdn_timer #(
   parameter int SHDN_DLY = 96
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pll_on,
   input  logic keep_on,
   output logic shdn_o
);

   localparam int CNT_W = $clog2(SHDN_DLY + 1);
   localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(SHDN_DLY);

   generate
      if (SHDN_DLY < 1) begin : g_bad_dly
         $error("pwr_shdn_timer: SHDN_DLY must be at least 1");
      end
   endgenerate

   logic [CNT_W-1:0] hold_cnt;

   // reloads while the PLL runs, counts down once it stops
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_cnt <= CNT_LOAD;
      end else if (pll_on) begin
         hold_cnt <= CNT_LOAD;
      end else if (hold_cnt != '0) begin
         hold_cnt <= hold_cnt - 1'b1;
      end
   end

   assign shdn_o = keep_on | pll_on | (hold_cnt != '0);

endmodule

// File: rtl/pwr_mode_ctl.sv
module pwr_mode_ctl
   import pwr_mode_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int SHDN_DLY    = 96
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cmd_valid,
   input  logic [4:0] cmd_addr,
   input  logic [7:0] cmd_data,
   input  logic       wake1_n,
   input  logic       wake2_n,
   input  logic       alarm_pulse,
   output logic [7:0] ctl_q,
   output logic [1:0] mode_q,
   output logic       shdn_o,
   output logic       adc_en,
   output logic       clkout_en,
   output logic       dout_oe,
   output logic       mon_sel
);

   localparam int NPINS = 2;

   logic      wake_evt;
   pwr_mode_e mode_r;

   pwr_wake_sync #(.NPINS(NPINS), .SYNC_STAGES(SYNC_STAGES)) u_wake (
      .clk         (clk),
      .rst_n       (rst_n),
      .pin_n       ({wake2_n, wake1_n}),
      .alarm_pulse (alarm_pulse),
      .wake_evt    (wake_evt)
   );

   pwr_ctl_core u_core (
      .clk       (clk),
      .rst_n     (rst_n),
      .cmd_valid (cmd_valid),
      .cmd_addr  (cmd_addr),
      .cmd_data  (cmd_data),
      .wake_evt  (wake_evt),
      .ctl_q     (ctl_q),
      .mode_q    (mode_r)
   );

   pwr_shdn_timer #(.SHDN_DLY(SHDN_DLY)) u_shdn (
      .clk     (clk),
      .rst_n   (rst_n),
      .pll_on  (ctl_q[B_PLL]),
      .keep_on (ctl_q[B_KEEP]),
      .shdn_o  (shdn_o)
   );

   assign mode_q    = mode_r;
   assign adc_en    = (mode_r == MODE_RUN);
   assign clkout_en = ctl_q[B_PLL];
   assign dout_oe   = ctl_q[B_DOE];
   assign mon_sel   = ctl_q[B_MSEL];

endmodule

// File: rtl/pwr_mode_ctl_chk.sv
module pwr_mode_ctl_chk
   import pwr_mode_pkg::*;
(
   input logic       clk,
   input logic       rst_n,
   input logic       cmd_valid,
   input logic [4:0] cmd_addr,
   input logic [7:0] cmd_data,
   input logic       wake_evt,
   input logic [7:0] ctl_q,
   input logic [1:0] mode_q,
   input logic       shdn_o
);

   a_r2_ctl_write: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_addr == A_CTL && !wake_evt)
      |=> (ctl_q == $past(cmd_data)) && (mode_q == $past(mode_q)));

   a_r3_sleep_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_addr == A_SLEEP && !wake_evt)
      |=> (mode_q == MODE_SLEEP) && !ctl_q[B_KEEP] && !ctl_q[B_PLL] && !ctl_q[B_BIAS]);

   a_r6_wake_forces: assert property (@(posedge clk) disable iff (!rst_n)
      wake_evt |=> ((ctl_q & WAKE_SET) == WAKE_SET) && (mode_q != MODE_SLEEP));

   a_r8_shdn_alive: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_q[B_KEEP] || ctl_q[B_PLL]) |-> shdn_o);

   a_r8_shdn_fall: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(shdn_o) |-> (!ctl_q[B_KEEP] && !ctl_q[B_PLL] && !$past(ctl_q[B_PLL])));

   a_r10_keep_bits: assert property (@(posedge clk) disable iff (!rst_n)
      (!(cmd_valid && cmd_addr == A_CTL))
      |=> (ctl_q[B_DOE] == $past(ctl_q[B_DOE])) && (ctl_q[B_MSEL] == $past(ctl_q[B_MSEL])));

   a_r12_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (!cmd_valid && !wake_evt) |=> ($stable(ctl_q) && $stable(mode_q)));

endmodule

bind pwr_mode_ctl pwr_mode_ctl_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cmd_valid (cmd_valid),
   .cmd_addr  (cmd_addr),
   .cmd_data  (cmd_data),
   .wake_evt  (wake_evt),
   .ctl_q     (ctl_q),
   .mode_q    (mode_q),
   .shdn_o    (shdn_o)
);

// File: tb/sim_pwr_mode_ctl.sv
module sim_pwr_mode_ctl;

   localparam int CLK_PERIOD  = 10;
   localparam int SYNC_STAGES = 2;
   localparam int SHDN_DLY    = 96;
   localparam int WDOG_CYC    = 150000;

   localparam logic [4:0] AD_CTL   = 5'b11001;
   localparam logic [4:0] AD_SLEEP = 5'b11010;
   localparam logic [4:0] AD_STBY  = 5'b11011;
   localparam logic [4:0] AD_IDLE  = 5'b11100;
   localparam logic [4:0] AD_RUN   = 5'b11101;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cmd_valid = 1'b0;
   logic [4:0] cmd_addr = '0;
   logic [7:0] cmd_data = '0;
   logic       wake1_n = 1'b1;
   logic       wake2_n = 1'b1;
   logic       alarm_pulse = 1'b0;
   logic [7:0] ctl_q;
   logic [1:0] mode_q;
   logic       shdn_o, adc_en, clkout_en, dout_oe, mon_sel;

   int n_vec = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   pwr_mode_ctl #(.SYNC_STAGES(SYNC_STAGES), .SHDN_DLY(SHDN_DLY)) u0 (
      .clk, .rst_n, .cmd_valid, .cmd_addr, .cmd_data, .wake1_n, .wake2_n,
      .alarm_pulse, .ctl_q, .mode_q, .shdn_o, .adc_en, .clkout_en,
      .dout_oe, .mon_sel
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic send(input logic [4:0] a, input logic [7:0] d);
      @(negedge clk);
      cmd_valid = 1'b1; cmd_addr = a; cmd_data = d;
      @(negedge clk);
      cmd_valid = 1'b0; cmd_addr = '0; cmd_data = '0;
   endtask

   task automatic send_with_alarm(input logic [4:0] a, input logic [7:0] d);
      @(negedge clk);
      cmd_valid = 1'b1; cmd_addr = a; cmd_data = d; alarm_pulse = 1'b1;
      @(negedge clk);
      cmd_valid = 1'b0; cmd_addr = '0; cmd_data = '0; alarm_pulse = 1'b0;
   endtask

   function automatic logic [7:0] exp_sleep(input logic [7:0] p);
      return {2'b00, ~p[1], p[1], 1'b0, p[2], p[1], 1'b0};
   endfunction

   task automatic t_reset;
      chk("R1 ctl", 32'(ctl_q), 32'hE1);
      chk("R1 mode", 32'(mode_q), 32'd1);
      chk("R1 shdn", 32'(shdn_o), 32'd1);
      chk("R1 adc", 32'(adc_en), 32'd0);
   endtask

   task automatic t_ctl_write;
      send(AD_CTL, 8'h5A);
      chk("R2 ctl 5A", 32'(ctl_q), 32'h5A);
      chk("R2 mode kept", 32'(mode_q), 32'd1);
      send(AD_CTL, 8'hCF);
      chk("R2 ctl CF", 32'(ctl_q), 32'hCF);
   endtask

   task automatic t_sleep;
      send(AD_SLEEP, 8'hFF);
      chk("R3 sleep msel1", 32'(ctl_q), 32'(exp_sleep(8'hCF)));
      chk("R3 mode", 32'(mode_q), 32'd0);
      send(AD_CTL, 8'hC4);
      chk("R2 mode in sleep", 32'(mode_q), 32'd0);
      send(AD_SLEEP, 8'h00);
      chk("R3 sleep msel0", 32'(ctl_q), 32'(exp_sleep(8'hC4)));
   endtask

   task automatic t_standby;
      send(AD_STBY, 8'h00);
      chk("R4 stby msel0", 32'(ctl_q), 32'hE5);
      chk("R4 mode", 32'(mode_q), 32'd1);
      send(AD_CTL, 8'h0A);
      send(AD_STBY, 8'h00);
      chk("R4 stby msel1", 32'(ctl_q), 32'hF3);
   endtask

   task automatic t_idle_run;
      send(AD_IDLE, 8'h00);
      chk("R5 idle ctl", 32'(ctl_q), 32'hFB);
      chk("R5 idle mode", 32'(mode_q), 32'd2);
      chk("R5 idle adc", 32'(adc_en), 32'd0);
      send(AD_RUN, 8'h00);
      chk("R5 run mode", 32'(mode_q), 32'd3);
      chk("R5 run adc", 32'(adc_en), 32'd1);
   endtask

   task automatic t_wake_pin;
      send(AD_SLEEP, 8'h00);
      chk("R6 pre sleep", 32'(ctl_q), 32'h12);
      wake1_n = 1'b0;
      repeat (SYNC_STAGES) @(posedge clk);
      @(negedge clk);
      chk("R6 not yet", 32'(mode_q), 32'd0);
      @(posedge clk);
      @(negedge clk);
      chk("R6 wake1 ctl", 32'(ctl_q), 32'hF3);
      chk("R6 wake1 mode", 32'(mode_q), 32'd1);
      wake1_n = 1'b1;
      repeat (SYNC_STAGES + 2) @(negedge clk);
      send(AD_IDLE, 8'h00);
      send(AD_CTL, 8'h00);
      wake2_n = 1'b0;
      repeat (SYNC_STAGES + 1) @(posedge clk);
      @(negedge clk);
      chk("R6 wake2 ctl", 32'(ctl_q), 32'hE1);
      chk("R6 idle kept", 32'(mode_q), 32'd2);
      wake2_n = 1'b1;
      repeat (SYNC_STAGES + 2) @(negedge clk);
   endtask

   task automatic t_alarm;
      send(AD_SLEEP, 8'h00);
      chk("R7 pre sleep", 32'(ctl_q), 32'h20);
      @(negedge clk); alarm_pulse = 1'b1;
      @(negedge clk); alarm_pulse = 1'b0;
      chk("R7 alarm ctl", 32'(ctl_q), 32'hE1);
      chk("R7 alarm mode", 32'(mode_q), 32'd1);
   endtask

   task automatic t_shdn_delay;
      send(AD_CTL, 8'h40);
      chk("R8 pll holds", 32'(shdn_o), 32'd1);
      send(AD_CTL, 8'h00);
      repeat (SHDN_DLY - 1) @(posedge clk);
      @(negedge clk);
      chk("R8 before expiry", 32'(shdn_o), 32'd1);
      @(posedge clk);
      @(negedge clk);
      chk("R8 at expiry", 32'(shdn_o), 32'd0);
      send(AD_CTL, 8'h80);
      repeat (SHDN_DLY + 4) @(negedge clk);
      chk("R8 keep bit holds", 32'(shdn_o), 32'd1);
      send(AD_CTL, 8'h00);
      chk("R8 no pll immediate", 32'(shdn_o), 32'd0);
   endtask

   task automatic t_restart;
      send(AD_CTL, 8'h40);
      send(AD_CTL, 8'h00);
      repeat (20) @(negedge clk);
      chk("R9 mid delay", 32'(shdn_o), 32'd1);
      send(AD_CTL, 8'h40);
      send(AD_CTL, 8'h00);
      repeat (SHDN_DLY - 1) @(posedge clk);
      @(negedge clk);
      chk("R9 restarted hold", 32'(shdn_o), 32'd1);
      @(posedge clk);
      @(negedge clk);
      chk("R9 restarted fall", 32'(shdn_o), 32'd0);
   endtask

   task automatic t_keep;
      send(AD_CTL, 8'h06);
      send(AD_IDLE, 8'h00);
      chk("R10 after idle", 32'(ctl_q[2:1]), 32'd3);
      send(AD_RUN, 8'h00);
      chk("R10 after run", 32'(ctl_q[2:1]), 32'd3);
      send(AD_STBY, 8'h00);
      chk("R10 after stby", 32'(ctl_q[2:1]), 32'd3);
      send(AD_SLEEP, 8'h00);
      chk("R10 after sleep", 32'(ctl_q[2:1]), 32'd3);
      chk("R10 dout_oe pin", 32'(dout_oe), 32'd1);
      @(negedge clk); alarm_pulse = 1'b1;
      @(negedge clk); alarm_pulse = 1'b0;
      chk("R10 after wake", 32'(ctl_q[2:1]), 32'd3);
      chk("R10 mon_sel pin", 32'(mon_sel), 32'd1);
   endtask

   task automatic t_collision;
      send(AD_SLEEP, 8'h00);
      send_with_alarm(AD_CTL, 8'h00);
      chk("R11 write+wake ctl", 32'(ctl_q), 32'hE1);
      chk("R11 write+wake mode", 32'(mode_q), 32'd1);
      send(AD_RUN, 8'h00);
      send_with_alarm(AD_SLEEP, 8'h00);
      chk("R11 sleep+wake mode", 32'(mode_q), 32'd1);
      chk("R11 sleep+wake bits", 32'(ctl_q[7:6]), 32'd3);
      chk("R11 clkout", 32'(clkout_en), 32'd1);
   endtask

   task automatic t_ignore;
      logic [7:0] c0;
      logic [1:0] m0;
      c0 = ctl_q; m0 = mode_q;
      send(5'b00011, 8'hFF);
      chk("R12 other addr ctl", 32'(ctl_q), 32'(c0));
      send(5'b11110, 8'h00);
      chk("R12 addr 11110 ctl", 32'(ctl_q), 32'(c0));
      chk("R12 addr 11110 mode", 32'(mode_q), 32'(m0));
      @(negedge clk);
      cmd_addr = AD_SLEEP; cmd_data = 8'h00;
      @(negedge clk);
      cmd_addr = AD_CTL; cmd_data = 8'h3C;
      @(negedge clk);
      cmd_addr = '0; cmd_data = '0;
      chk("R12 no strobe ctl", 32'(ctl_q), 32'(c0));
      chk("R12 no strobe mode", 32'(mode_q), 32'(m0));
   endtask

   initial begin
      repeat (WDOG_CYC) @(posedge clk);
      if (!done) begin
         n_vec++;
         n_bad++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_ctl_write();
      t_sleep();
      t_standby();
      t_idle_run();
      t_wake_pin();
      t_alarm();
      t_shdn_delay();
      t_restart();
      t_keep();
      t_collision();
      t_ignore();
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule